// File: doc/BRIEF.md
# Multi-Device SYNC Request Combiner

This block sits in the link-layer logic device of a converter group that runs without a shared timing reference pulse. Each converter drives an active-low SYNC request. The block brings every request into the local clock domain, drops the devices that are switched off, and merges the rest into one group request. That request is released only when every enabled device has released its own.

The merged request is not passed straight through. A change to it is held until the next frame strobe. At that clock edge it is applied to the redistributed SYNC output, so every converter that receives this output sees the transition in the same frame clock period.

The same frame-strobe decision drives the transmit side. Once the group is released, a one-cycle ILAS start pulse is issued on the first multiframe boundary. All lanes of all devices then begin their initial lane alignment sequence together.

Top module: `sync_combiner`

## Requirements
- R1: While reset is held and after it is released, `sync_n_o` is low (request asserted) and `ilas_start_o` is low until the first qualifying frame strobe.
- R2: Each `sync_n_i` bit passes through a two-flop synchronizer. An input changed just before clock edge E1 is first used by a frame strobe sampled at edge E3. A strobe sampled at edge E2 still uses the old value.
- R3: The merged request is active (low) while at least one enabled device holds its `sync_n_i` low. It is released (high) only when all enabled devices are high.
- R4: A device whose `dev_mask_i` bit is 1 is excluded, and its `sync_n_i` level has no effect on the outputs.
- R5: `sync_n_o` changes only at a clock edge where `frame_stb_i` is high. At that edge it takes the merged value, and it holds between strobes whatever the inputs do.
- R6: `ilas_start_o` is a single-cycle pulse. It is issued at the first multiframe-boundary strobe at which the merged request is released, and this includes the strobe that applies the release.
- R7: Multiframe boundaries are the frame strobes numbered 0, MF_FRAMES, 2*MF_FRAMES and so on, counting strobes from reset.
- R8: A request that reappears at a strobe drives `sync_n_o` low and cancels a pending ILAS start. A later release waits for a new boundary.
- R9: After an ILAS start, no further pulse is issued while the group stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_n_i | input | NUM_DEV | Per-device SYNC request, active low, asynchronous |
| dev_mask_i | input | NUM_DEV | 1 excludes the device from the merge |
| frame_stb_i | input | 1 | One-cycle frame clock strobe |
| sync_n_o | output | 1 | Redistributed SYNC, active low, changes only on a strobe edge |
| ilas_start_o | output | 1 | One-cycle ILAS start pulse |

## Verification
`sync_n_o` and `ilas_start_o` are registered at the strobe edge, so the monitor compares them at the falling edge that follows each strobe. An input change needs two edges through the synchronizer before a strobe can use it. The driver therefore waits three quiet cycles before it records the new input as effective. It also places one strobe deliberately at the second edge, where the old value must still apply. Between strobes, idle cycles check that `sync_n_o` holds and that no pulse appears.

// File: rtl/sync_comb_pkg.sv
package sync_comb_pkg;
  typedef enum logic [1:0] {
    LNK_REQ  = 2'd0,
    LNK_WAIT = 2'd1,
    LNK_RUN  = 2'd2
  } lnk_state_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sync_bit_sync.sv
module sync_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // reset to 0 = request held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sync_req_merge.sv
module sync_req_merge #(
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_DEV-1:0] sync_n_i,
  input  logic [NUM_DEV-1:0] mask_i,
  output logic               merged_n_o
);
  // masked devices read as released
  assign merged_n_o = &(sync_n_i | mask_i);
endmodule

// File: rtl/mf_tracker.sv
module mf_tracker #(
  parameter int MF_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_stb_i,
  output logic mf_edge_o
);
  import sync_comb_pkg::*;
  localparam int CW = cnt_width(MF_FRAMES);
  localparam logic [CW-1:0] LAST = CW'(MF_FRAMES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (frame_stb_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign mf_edge_o = frame_stb_i && (cnt_q == '0);

  // R7
  mf_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R7
  mf_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable(cnt_q));
endmodule

// File: rtl/link_start_fsm.sv
module link_start_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_stb_i,
  input  logic mf_edge_i,
  input  logic merged_n_i,
  output logic sync_n_o,
  output logic ilas_start_o
);
  import sync_comb_pkg::*;

  lnk_state_e state_q, state_d;
  logic       ilas_d, ilas_q;

  always_comb begin
    state_d = state_q;
    ilas_d  = 1'b0;
    if (frame_stb_i) begin
      if (!merged_n_i) begin
        state_d = LNK_REQ;
      end else begin
        unique case (state_q)
          LNK_REQ, LNK_WAIT: begin
            if (mf_edge_i) begin
              state_d = LNK_RUN;
              ilas_d  = 1'b1;
            end else begin
              state_d = LNK_WAIT;
            end
          end
          default: state_d = LNK_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LNK_REQ;
      ilas_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ilas_q  <= ilas_d;
    end
  end

  assign sync_n_o     = (state_q != LNK_REQ);
  assign ilas_start_o = ilas_q;

  // R5
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_n_o) |-> $past(frame_stb_i));
  // R6
  ilas_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilas_start_o |=> !ilas_start_o);
  // R6
  ilas_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilas_start_o |-> ($past(mf_edge_i) && sync_n_o));
  // R8
  fell_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_n_o) |-> !$past(merged_n_i));
  // R9
  no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LNK_RUN && $past(state_q) == LNK_RUN) |-> !ilas_start_o);
endmodule

// File: rtl/sync_combiner.sv
module sync_combiner #(
  parameter int NUM_DEV     = 4,
  parameter int MF_FRAMES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] sync_n_i,
  input  logic [NUM_DEV-1:0] dev_mask_i,
  input  logic               frame_stb_i,
  output logic               sync_n_o,
  output logic               ilas_start_o
);
  logic [NUM_DEV-1:0] sync_s;
  logic               merged_n;
  logic               mf_edge;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    sync_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sync_n_i[d]),
      .q_o   (sync_s[d])
    );
  end

  sync_req_merge #(.NUM_DEV(NUM_DEV)) u_merge (
    .sync_n_i  (sync_s),
    .mask_i    (dev_mask_i),
    .merged_n_o(merged_n)
  );

  mf_tracker #(.MF_FRAMES(MF_FRAMES)) u_mf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_stb_i(frame_stb_i),
    .mf_edge_o  (mf_edge)
  );

  link_start_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_stb_i (frame_stb_i),
    .mf_edge_i   (mf_edge),
    .merged_n_i  (merged_n),
    .sync_n_o    (sync_n_o),
    .ilas_start_o(ilas_start_o)
  );

  // R3
  rel_needs_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_n_o) |-> $past(&(sync_s | dev_mask_i)));
endmodule

// File: tb/sync_combiner_test.sv
module sync_combiner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;
  localparam int MF = 4;

  typedef struct {
    bit    s;
    bit    i;
    string req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NDEV-1:0] sync_n_i = '0;
  logic [NDEV-1:0] dev_mask_i = '0;
  logic            frame_stb_i = 1'b0;
  logic            sync_n_o, ilas_start_o;

  int checks = 0, failures = 0;
  exp_t q[$];
  logic [NDEV-1:0] eff_sync = '0, eff_mask = '0;
  int  scnt = 0;
  int  st = 0;       // 0 req, 1 wait, 2 run
  bit  cur_s = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_combiner #(.NUM_DEV(NDEV), .MF_FRAMES(MF), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_n_i(sync_n_i), .dev_mask_i(dev_mask_i),
    .frame_stb_i(frame_stb_i), .sync_n_o(sync_n_o), .ilas_start_o(ilas_start_o)
  );

  task automatic chk(input bit act_s, input bit act_i, input bit exp_s, input bit exp_i, input string req);
    checks++;
    if (act_s !== exp_s || act_i !== exp_i) begin
      failures++;
      $display("FAIL %s sync_n_o=%0b ilas=%0b expected sync_n_o=%0b ilas=%0b", req, act_s, act_i, exp_s, exp_i);
    end
  endtask

  // expected outcome from requirements R3..R9
  task automatic strobe(input string req);
    exp_t e;
    bit merged, bnd;
    merged = &(eff_sync | eff_mask);
    bnd = (scnt % MF) == 0;
    scnt++;
    if (!merged) begin st = 0; e.s = 0; e.i = 0; end
    else if (st == 2) begin e.s = 1; e.i = 0; end
    else if (bnd) begin st = 2; e.s = 1; e.i = 1; end
    else begin st = 1; e.s = 1; e.i = 0; end
    e.req = req;
    cur_s = e.s;
    @(negedge clk);
    q.push_back(e);
    frame_stb_i = 1'b1;
    @(negedge clk);
    frame_stb_i = 1'b0;
  endtask

  task automatic set_in(input logic [NDEV-1:0] s, input logic [NDEV-1:0] m);
    sync_n_i = s;
    dev_mask_i = m;
  endtask

  // quiet cycles: output holds, no pulse (R5, R9)
  task automatic settle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(sync_n_o, ilas_start_o, cur_s, 1'b0, req);
    end
    eff_sync = sync_n_i;
    eff_mask = dev_mask_i;
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    if (frame_stb_i && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      @(negedge clk);
      chk(sync_n_o, ilas_start_o, e.s, e.i, e.req);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sync_n_o, ilas_start_o, 1'b0, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    settle(3, "R1 after reset");
    strobe("R3 all low");                       // strobe 0
    @(negedge clk); set_in(4'b0111, 4'b0000);
    settle(3, "R5 hold");
    strobe("R3 one device still low");          // 1
    // R2: change right before strobe must not be seen
    set_in(4'b1111, 4'b0000);
    strobe("R2 too early");                     // 2
    settle(3, "R5 hold");
    strobe("R6 release off boundary");          // 3 -> wait
    strobe("R6 R7 boundary pulse");             // 4 -> ilas
    settle(3, "R6 single pulse");
    strobe("R9 no repeat");                     // 5
    @(negedge clk); set_in(4'b1101, 4'b0000);
    settle(3, "R5 hold");
    strobe("R8 request returns");               // 6
    @(negedge clk); set_in(4'b1111, 4'b0000);
    settle(3, "R5 hold");
    strobe("R6 pending");                       // 7
    @(negedge clk); set_in(4'b1011, 4'b0000);
    settle(3, "R5 hold");
    strobe("R8 cancel pending at boundary");    // 8
    @(negedge clk); set_in(4'b1111, 4'b0000);
    settle(3, "R5 hold");
    strobe("R8 wait new boundary");             // 9
    strobe("R8 wait new boundary");             // 10
    strobe("R8 wait new boundary");             // 11
    strobe("R7 R8 pulse at strobe 12");         // 12
    @(negedge clk); set_in(4'b1110, 4'b0001);
    settle(3, "R4 masked low ignored");
    strobe("R4 masked low ignored");            // 13
    @(negedge clk); set_in(4'b1110, 4'b0000);
    settle(3, "R5 hold");
    strobe("R4 unmasked low seen");             // 14
    @(negedge clk); set_in(4'b1110, 4'b0001);
    settle(3, "R5 hold");
    strobe("R4 mask releases");                 // 15
    strobe("R4 R7 pulse at strobe 16");         // 16
    @(negedge clk); set_in(4'b0000, 4'b0000);
    settle(10, "R5 no change without strobe");
    strobe("R5 applied at strobe");             // 17
    settle(2, "R5 hold");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule